// File: doc/BRIEF.md
# I2C Target Controller with CPU-Paced Clock Stretching

This block answers as a target on a two-wire I2C bus using 7-bit addresses. The SCL and SDA pads are sampled through a short synchronizer chain running on the system clock, which must be at least eight times faster than SCL. The block drives both lines only as open-drain pull-down enables. It finds Start, repeated Start and Stop conditions. It takes in the address/direction byte, then either takes in data bytes from the controller or shifts data bytes out to it.

Each byte is paced by the local CPU. When a byte completes, the block raises its interrupt. On the next SCL low phase it pins SCL low until the CPU writes a command that acknowledges, refuses or (when sending) releases the next byte. Address matching is done in one of two ways, chosen by a configuration bit:
- By firmware: every address byte is presented to the CPU.
- By hardware: a mismatched address is silently refused, with no interrupt and no stretch.

The CPU side is a single-cycle register port with no back-pressure. Writes take effect on the next clock and reads are combinational. The only flow control in the design runs toward the bus: holding SCL low is the back-pressure that stops the controller until the CPU has consumed or supplied a byte.

Top module: `i2cs_slave`

Register map. `reg_addr` selects the register.
- 0, configuration (read/write): bit 0 enables the block, bit 1 selects hardware address compare.
- 1, own address (read/write): bits 6:0.
- 2, command on write and status on read.
  - Write: bit 0 = acknowledge/proceed, bit 1 = refuse. Refuse wins when both bits are set. Any write to this register clears the interrupt and the Start/Stop flags.
  - Read: bit 0 = Start seen, bit 1 = Stop seen, bit 2 = last byte was an address, bit 3 = direction bit of the last address (1 = target sends), bit 4 = controller acknowledged the last sent byte, bit 5 = SCL is being held, bit 6 = interrupt pending.
- 3, data: a write loads the byte to send, a read returns the last byte taken in.

## Requirements
- R1: While enabled, SDA falling with SCL high starts address reception; it sets status bit 0. The received address/direction byte is readable at register 3 and its direction appears in status bit 3.
- R2: In firmware-compare mode every address byte raises the interrupt. SCL is then held low, and it is released in the cycle after a command write with bit 0 or bit 1 set.
- R3: In hardware-compare mode an address other than the own address causes no interrupt and no SCL hold. SDA is left released in the ninth bit, so the controller sees a refusal.
- R4: In hardware-compare mode the own address raises the interrupt and holds SCL until the CPU commands an acknowledge.
- R5: In receive direction each data byte raises the interrupt and holds SCL; the byte is readable at register 3. An acknowledge command drives SDA low for the ninth bit.
- R6: A refuse command (bit 1, priority over bit 0) leaves SDA released in the ninth bit. The block then ignores all bus bits until a Stop or a repeated Start; a repeated Start begins a new address reception.
- R7: In send direction the byte in register 3 goes out MSB first, and SDA changes only while SCL is low.
- R8: An acknowledge from the controller after a sent byte sets status bit 4, raises the interrupt and holds SCL until a command write. A refusal clears bit 4 and raises the interrupt without holding SCL, and both lines are released.
- R9: SDA rising with SCL high returns the block to idle from any state. It releases both lines and sets status bit 1.
- R10: While disabled, the block never drives either line and sets no flag.
- R11: While SCL is held, SDA is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL pad level |
| sda_i | input | 1 | SDA pad level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Byte-complete interrupt, level |

## Verification
The bench sweeps all 128 addresses in hardware-compare mode against a fixed own address. A comparator off by one bit, or one that compared the direction bit, would stretch or acknowledge on a wrong address, or would stay silent on the right one.

Several directed checks follow:
- A receive burst of corner data values checks each byte as received, with its acknowledge.
- A refusal given with both command bits set shows whether refuse really wins, and the byte after it must go unanswered.
- A repeated Start into a send transfer checks the MSB-first order.
- The controller's acknowledge must stretch and its refusal must not; a design that stretched after a refusal would hang the bus.
- Stop handling and the disabled state are checked at the pins and in the status register.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int unsigned RA_W = 2;
  localparam logic [RA_W-1:0] RA_CFG  = 2'd0;
  localparam logic [RA_W-1:0] RA_OWN  = 2'd1;
  localparam logic [RA_W-1:0] RA_CMD  = 2'd2;
  localparam logic [RA_W-1:0] RA_DATA = 2'd3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_HOLD, ST_ACK, ST_TX, ST_TXACK, ST_TXHOLD, ST_SKIP
  } eng_state_t;

  typedef struct packed {
    logic irq;
    logic stalled;
    logic mack;
    logic rw;
    logic addr;
    logic stop;
    logic start;
  } status_t;
endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d,
  output logic [LINES-1:0] q
);
  logic [STAGES-1:0][LINES-1:0] stg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg <= '1;
    end else begin
      stg[0] <= d;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cs_busmon.sv
module i2cs_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              hw_cmp,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              go_ack,
  input  logic              go_nak,
  input  logic [DATA_W-1:0] tx_byte,
  output logic              scl_drv,
  output logic              sda_drv,
  output logic              byte_ev,
  output logic [DATA_W-1:0] rx_byte,
  output logic              is_addr,
  output logic              rw,
  output logic              mack
);
  localparam int unsigned CW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST = CW'(DATA_W - 1);
  localparam logic [CW-1:0] FULL = CW'(DATA_W);

  eng_state_t        state;
  logic [CW-1:0]     cnt;
  logic [DATA_W-1:0] shreg;
  logic              refused;
  logic              go;
  logic              addr_hit;

  assign go       = go_ack | go_nak;
  assign addr_hit = (shreg[ADDR_W-1:0] == own_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      rx_byte <= '0;
      is_addr <= 1'b0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      refused <= 1'b0;
      scl_drv <= 1'b0;
      sda_drv <= 1'b0;
      byte_ev <= 1'b0;
    end else begin
      byte_ev <= 1'b0;
      if (!en || stop_ev) begin
        state   <= ST_IDLE;
        scl_drv <= 1'b0;
        sda_drv <= 1'b0;
      end else if (start_ev) begin
        state   <= ST_RX;
        cnt     <= '0;
        is_addr <= 1'b1;
        scl_drv <= 1'b0;
        sda_drv <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise && cnt != FULL) begin
              shreg <= {shreg[DATA_W-2:0], sda_s};
              cnt   <= cnt + 1'b1;
              if (cnt == LAST) begin
                rx_byte <= {shreg[DATA_W-2:0], sda_s};
                if (is_addr) begin
                  rw <= sda_s;
                  if (hw_cmp && !addr_hit) state <= ST_SKIP;
                  else byte_ev <= 1'b1;
                end else begin
                  byte_ev <= 1'b1;
                end
              end
            end else if (scl_fall && cnt == FULL) begin
              state   <= ST_HOLD;
              scl_drv <= 1'b1;
            end
          end
          ST_HOLD: begin
            if (go) begin
              sda_drv <= go_ack & ~go_nak;
              refused <= go_nak;
              scl_drv <= 1'b0;
              state   <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (refused) begin
                sda_drv <= 1'b0;
                state   <= ST_SKIP;
              end else if (is_addr && rw) begin
                shreg   <= tx_byte;
                sda_drv <= ~tx_byte[DATA_W-1];
                is_addr <= 1'b0;
                state   <= ST_TX;
              end else begin
                sda_drv <= 1'b0;
                is_addr <= 1'b0;
                state   <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_drv <= 1'b0;
                state   <= ST_TXACK;
              end else begin
                shreg   <= {shreg[DATA_W-2:0], 1'b0};
                sda_drv <= ~shreg[DATA_W-2];
                cnt     <= cnt + 1'b1;
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              mack    <= ~sda_s;
              byte_ev <= 1'b1;
            end else if (scl_fall) begin
              if (mack) begin
                scl_drv <= 1'b1;
                state   <= ST_TXHOLD;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_TXHOLD: begin
            if (go) begin
              shreg   <= tx_byte;
              sda_drv <= ~tx_byte[DATA_W-1];
              scl_drv <= 1'b0;
              cnt     <= '0;
              state   <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regs.sv
module i2cs_regs
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              byte_ev,
  input  logic [DATA_W-1:0] rx_byte,
  input  logic              is_addr,
  input  logic              rw,
  input  logic              mack,
  input  logic              stalled,
  output logic              en,
  output logic              hw_cmp,
  output logic [ADDR_W-1:0] own_addr,
  output logic [DATA_W-1:0] tx_byte,
  output logic              go_ack,
  output logic              go_nak,
  output logic              irq
);
  localparam int unsigned SW = $bits(status_t);

  logic    cmd_wr;
  logic    start_seen, stop_seen;
  status_t st;

  assign cmd_wr = reg_wr && reg_addr == RA_CMD;
  assign go_ack = cmd_wr & reg_wdata[0];
  assign go_nak = cmd_wr & reg_wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en         <= 1'b0;
      hw_cmp     <= 1'b0;
      own_addr   <= '0;
      tx_byte    <= '0;
      irq        <= 1'b0;
      start_seen <= 1'b0;
      stop_seen  <= 1'b0;
    end else begin
      if (reg_wr && reg_addr == RA_CFG) begin
        en     <= reg_wdata[0];
        hw_cmp <= reg_wdata[1];
      end
      if (reg_wr && reg_addr == RA_OWN) own_addr <= reg_wdata[ADDR_W-1:0];
      if (reg_wr && reg_addr == RA_DATA) tx_byte <= reg_wdata;
      if (cmd_wr) begin
        irq        <= 1'b0;
        start_seen <= 1'b0;
        stop_seen  <= 1'b0;
      end
      if (en && byte_ev)  irq        <= 1'b1;
      if (en && start_ev) start_seen <= 1'b1;
      if (en && stop_ev)  stop_seen  <= 1'b1;
    end
  end

  always_comb begin
    st.irq     = irq;
    st.stalled = stalled;
    st.mack    = mack;
    st.rw      = rw;
    st.addr    = is_addr;
    st.stop    = stop_seen;
    st.start   = start_seen;
    unique case (reg_addr)
      RA_CFG:  reg_rdata = DATA_W'({hw_cmp, en});
      RA_OWN:  reg_rdata = DATA_W'(own_addr);
      RA_CMD:  reg_rdata = DATA_W'(st[SW-1:0]);
      default: reg_rdata = rx_byte;
    endcase
  end
endmodule

// File: rtl/i2cs_slave.sv
module i2cs_slave
  import i2cs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic [1:0]        pads_s;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              cfg_en, hw_cmp, go_ack, go_nak;
  logic [ADDR_W-1:0] own_addr;
  logic [DATA_W-1:0] tx_byte, rx_byte;
  logic              byte_ev, is_addr, rw, mack;

  i2cs_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(pads_s)
  );

  i2cs_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_s(pads_s[1]), .sda_s(pads_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cs_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .hw_cmp(hw_cmp),
    .own_addr(own_addr), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(pads_s[0]), .start_ev(start_ev), .stop_ev(stop_ev),
    .go_ack(go_ack), .go_nak(go_nak), .tx_byte(tx_byte),
    .scl_drv(scl_oe), .sda_drv(sda_oe), .byte_ev(byte_ev),
    .rx_byte(rx_byte), .is_addr(is_addr), .rw(rw), .mack(mack)
  );

  i2cs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .start_ev(start_ev), .stop_ev(stop_ev), .byte_ev(byte_ev),
    .rx_byte(rx_byte), .is_addr(is_addr), .rw(rw), .mack(mack),
    .stalled(scl_oe), .en(cfg_en), .hw_cmp(hw_cmp), .own_addr(own_addr),
    .tx_byte(tx_byte), .go_ack(go_ack), .go_nak(go_nak), .irq(irq)
  );
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_i,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       irq,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [1:0] cmd_bits,
  input logic       cfg_en,
  input logic       stop_ev
);
  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en && $past(cfg_en) && !$stable(sda_oe) |-> !scl_i);  // R7
  AST_HOLD_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> irq);  // R2
  AST_CMD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe && reg_wr && reg_addr == 2'd2 && cmd_bits != 2'b00 |=> !scl_oe);  // R2
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !scl_oe && !sda_oe);  // R9
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !scl_oe && !sda_oe);  // R10
  AST_HOLD_SDA_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    scl_oe |-> !sda_oe);  // R11
endmodule

bind i2cs_slave i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr), .cmd_bits(reg_wdata[1:0]),
  .cfg_en(cfg_en), .stop_ev(stop_ev)
);

// File: tb/tb_i2cs_slave.sv
module tb_i2cs_slave;
  localparam int HALF = 10;
  localparam logic [6:0] OWN = 7'h2D;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_line, sda_line;
  logic       scl_oe, sda_oe, irq;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  int         n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  assign scl_line = scl_m & ~scl_oe;
  assign sda_line = sda_m & ~sda_oe;

  i2cs_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic pulse(output logic s);
    scl_m = 1'b1;
    while (!scl_line) @(negedge clk);
    wait_n(HALF);
    s = sda_line;
    scl_m = 1'b0;
    wait_n(4);
  endtask

  task automatic bus_start();
    scl_m = 1'b0; sda_m = 1'b1;
    wait_n(4);
    scl_m = 1'b1; wait_n(HALF);
    sda_m = 1'b0; wait_n(HALF);
    scl_m = 1'b0; wait_n(4);
  endtask

  task automatic bus_stop();
    scl_m = 1'b0; sda_m = 1'b0; wait_n(HALF);
    scl_m = 1'b1; wait_n(HALF);
    sda_m = 1'b1; wait_n(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i];
      wait_n(HALF - 4);
      pulse(s);
    end
    sda_m = 1'b1;
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic s;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_n(HALF - 4);
      pulse(s);
      b[i] = s;
    end
  endtask

  task automatic ninth(input logic drive_nak, output logic s);
    sda_m = drive_nak;
    wait_n(HALF - 4);
    pulse(s);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R1-watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic       s;
    logic [7:0] rxv [4];
    rxv[0] = 8'h00; rxv[1] = 8'hFF; rxv[2] = 8'hA5; rxv[3] = 8'h3C;

    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    // reset state
    chk("R10 reset scl_oe", scl_oe, 0);
    chk("R10 reset sda_oe", sda_oe, 0);
    chk("R10 reset irq", irq, 0);
    rd(2'd2, v); chk("R10 reset status", v, 8'h00);

    // R10: disabled block stays silent
    bus_start();
    send_byte({OWN, 1'b0});
    wait_n(2);
    chk("R10 no hold while off", scl_oe, 0);
    ninth(1'b1, s);
    chk("R10 no ack while off", s, 1);
    bus_stop();
    rd(2'd2, v); chk("R10 no flags while off", v, 8'h00);

    // firmware compare, receive direction
    wr(2'd0, 8'h01);
    bus_start();
    send_byte(8'hAA);
    wait_n(2);
    chk("R2 hold after address", scl_oe, 1);
    chk("R2 irq after address", irq, 1);
    rd(2'd2, v); chk("R1 status after write address", v, 8'h65);
    rd(2'd3, v); chk("R1 address byte readable", v, 8'hAA);
    wr(2'd2, 8'h01);
    chk("R2 released by command", scl_oe, 0);
    ninth(1'b1, s);
    chk("R5 address acked", s, 0);
    for (int k = 0; k < 4; k++) begin
      send_byte(rxv[k]);
      wait_n(2);
      chk("R5 hold after data", scl_oe, 1);
      rd(2'd2, v); chk("R5 status after data", v, 8'h60);
      rd(2'd3, v); chk("R5 data byte", v, rxv[k]);
      if (k == 3) begin
        wr(2'd2, 8'h03);
        ninth(1'b1, s);
        chk("R6 refuse wins, SDA free", s, 1);
      end else begin
        wr(2'd2, 8'h01);
        ninth(1'b1, s);
        chk("R5 data acked", s, 0);
      end
    end
    send_byte(8'h81);
    wait_n(2);
    chk("R6 bytes after refuse not held", scl_oe, 0);
    ninth(1'b1, s);
    chk("R6 bytes after refuse not acked", s, 1);

    // repeated start into send direction
    bus_start();
    send_byte(8'hAB);
    wait_n(2);
    rd(2'd2, v); chk("R6 restart gives address status", v, 8'h6D);
    wr(2'd3, 8'hC3);
    wr(2'd2, 8'h01);
    ninth(1'b1, s);
    chk("R7 read address acked", s, 0);
    read_byte(v);
    chk("R7 first sent byte MSB first", v, 8'hC3);
    ninth(1'b0, s);
    wait_n(2);
    chk("R8 hold after controller ack", scl_oe, 1);
    rd(2'd2, v); chk("R8 status after controller ack", v, 8'h78);
    wr(2'd3, 8'h5A);
    wr(2'd2, 8'h01);
    read_byte(v);
    chk("R7 second sent byte", v, 8'h5A);
    ninth(1'b1, s);
    wait_n(2);
    chk("R8 no hold after controller refusal", scl_oe, 0);
    chk("R8 SDA free after refusal", sda_oe, 0);
    rd(2'd2, v); chk("R8 status after refusal", v, 8'h48);
    bus_stop();
    wait_n(2);
    rd(2'd2, v); chk("R9 stop flag", v, 8'h4A);
    chk("R9 lines free after stop", {scl_oe, sda_oe}, 0);

    // hardware compare sweep over all addresses
    wr(2'd2, 8'h00);
    wr(2'd1, {1'b0, OWN});
    wr(2'd0, 8'h03);
    for (int a = 0; a < 128; a++) begin
      bus_start();
      send_byte({a[6:0], 1'b0});
      wait_n(2);
      if (a[6:0] == OWN) begin
        chk("R4 own address held", scl_oe, 1);
        chk("R4 own address irq", irq, 1);
        wr(2'd2, 8'h01);
        ninth(1'b1, s);
        chk("R4 own address acked", s, 0);
      end else begin
        chk("R3 foreign address not held", scl_oe, 0);
        chk("R3 foreign address no irq", irq, 0);
        ninth(1'b1, s);
        chk("R3 foreign address refused", s, 1);
      end
      bus_stop();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule